// File: doc/BRIEF.md
# Serial Run-Control Command Receiver

This block listens to a single serial line that used to carry a plain trigger level and now carries short command words. Each word is four bits, Manchester coded, and preceded by a quiet period and a marker bit. The receiver resynchronises the line to a fast sampling clock, waits for a valid start, and recovers the bits by sampling the middle of each half-bit. It checks every bit for its mid-bit transition and then turns the word into one run-control strobe.

The strobes it produces are: trigger on, trigger off, veto run, stop, data dump (which selects raw data transfer in place of processed readout), and gated-mode sequence start. The line level on its own never causes an action. Only a complete, correctly coded word with a known code does. A coding fault raises a one-cycle error flag and the word is dropped. The sequencer and the readout path that act on the strobes are outside this block.

Top module: `mc_trig_cmd_rx`

## Requirements
- R1: After reset, `cmd_strb` is all zero, `cmd_code` is 0 and `cmd_err` is 0.
- R2: A bit is Manchester coded: a 1 is a high half followed by a low half, and a 0 is a low half followed by a high half. Each half lasts `HALF_CLKS` (default 4) sampling clocks. Data bits are sent most significant first.
- R3: A word is accepted only if the synchronised line has been low for at least `IDLE_HALVES` (default 8) half-bit periods. After that comes a marker bit of value 1, followed by the four data bits. A rise after a shorter low period starts nothing.
- R4: Codes map to strobe bits as follows: 4'h1 is trigger on (bit 0), 4'h2 is trigger off (bit 1), 4'h3 is veto run (bit 2), 4'h4 is stop (bit 3), 4'h5 is data dump (bit 4) and 4'h6 is gated-mode start (bit 5). A valid command also loads its code into `cmd_code`.
- R5: Each valid command gives exactly one strobe, and that strobe is high for exactly one cycle. With the line driven just after a clock edge, the strobe is high in the cycle that begins on the second rising edge after the line leaves its last half-bit.
- R6: Codes 4'h0 and 4'h7 to 4'hF produce no strobe and no error, and leave `cmd_code` unchanged.
- R7: A bit whose two halves read the same (this includes a marker whose second half stays high) raises `cmd_err` for one cycle. The word is discarded and no strobe follows.
- R8: Holding the line at a steady level causes no command. A long high level after a valid idle gives at most a single error pulse.
- R9: At most one bit of `cmd_strb` is high in any cycle, and `cmd_err` is never high together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_line | input | 1 | Serial command line (asynchronous) |
| cmd_strb | output | 6 | One-cycle command strobes, bit order as in R4 |
| cmd_code | output | 4 | Code of the last valid command |
| cmd_err | output | 1 | One-cycle coding error flag |

## Verification
The hardest case to reach from the pins is a word that fails partway through. The receiver has to drop it, go back to waiting, and refuse every later edge inside the same burst until a full quiet period has passed. The bench builds such words on purpose: it flattens one chosen half-bit, holds the line high for far longer than a bit, and shortens the idle gap before an otherwise good word. The counts of strobes and errors after each case must match what the bench expects. Random frames with random codes and random idle lengths are mixed in between these cases, so recovery is tested from many different states.

// File: rtl/mc_cmd_pkg.sv
package mc_cmd_pkg;
  localparam int CMD_W   = 4;
  localparam int NUM_CMD = 6;

  typedef enum logic [CMD_W-1:0] {
    CODE_NONE     = 4'h0,
    CODE_TRIG_ON  = 4'h1,
    CODE_TRIG_OFF = 4'h2,
    CODE_VETO     = 4'h3,
    CODE_STOP     = 4'h4,
    CODE_DUMP     = 4'h5,
    CODE_GATED    = 4'h6
  } cmd_code_e;

  typedef enum logic {FR_IDLE, FR_RX} fr_state_e;
endpackage

// File: rtl/mc_sync.sv
module mc_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic line_rise
);
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[SYNC_STAGES-1:0], line_in};
  end

  assign line_s    = pipe[SYNC_STAGES-1];
  assign line_rise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
endmodule

// File: rtl/mc_framer.sv
module mc_framer
  import mc_cmd_pkg::*;
#(
  parameter int HALF_CLKS   = 4,
  parameter int IDLE_HALVES = 8,
  parameter int WORD_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              line_rise,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              sym_err
);
  localparam int BIT_CLKS  = 2 * HALF_CLKS;
  localparam int CW        = $clog2(BIT_CLKS);
  localparam int IDLE_CLKS = IDLE_HALVES * HALF_CLKS;
  localparam int IW        = $clog2(IDLE_CLKS + 1);
  localparam int BW        = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] MID0  = CW'(HALF_CLKS / 2);
  localparam logic [CW-1:0] MID1  = CW'(HALF_CLKS + HALF_CLKS / 2);
  localparam logic [CW-1:0] LAST  = CW'(BIT_CLKS - 1);
  localparam logic [IW-1:0] IDLE_FULL = IW'(IDLE_CLKS);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W);

  fr_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [IW-1:0]     idle_cnt;
  logic              h0;
  logic [WORD_W-1:0] shreg;
  logic              armed;

  assign armed = (idle_cnt == IDLE_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      idle_cnt <= '0;
      h0       <= 1'b0;
      shreg    <= '0;
    end else begin
      case (state)
        FR_IDLE: begin
          if (line_rise && armed) begin
            state    <= FR_RX;
            cnt      <= CW'(1);
            bidx     <= '0;
            idle_cnt <= '0;
          end else if (line) begin
            idle_cnt <= '0;
          end else if (!armed) begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        FR_RX: begin
          if (cnt == MID0) h0 <= line;
          if (cnt == MID1) begin
            if (line == h0) state <= FR_IDLE;
            else            shreg <= {shreg[WORD_W-2:0], h0};
          end
          if (cnt == LAST) begin
            cnt <= '0;
            if (bidx == LAST_BIT) state <= FR_IDLE;
            else                  bidx  <= bidx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assign sym_err  = (state == FR_RX) && (cnt == MID1) && (line == h0);
  assign word_vld = (state == FR_RX) && (cnt == LAST) && (bidx == LAST_BIT);
  assign word     = shreg;

  AST_ERR_DROPS_WORD: assert property (@(posedge clk) disable iff (rst)
    sym_err |=> (state == FR_IDLE) && (idle_cnt == '0)); // R7
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == FR_IDLE) && !armed |=> (state == FR_IDLE)); // R3
endmodule

// File: rtl/mc_decode.sv
module mc_decode
  import mc_cmd_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int N_CMD  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              sym_err,
  output logic [N_CMD-1:0]  cmd_strb,
  output logic [WORD_W-1:0] cmd_code,
  output logic              cmd_err
);
  logic [N_CMD-1:0] hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < N_CMD; i++)
      if (word == WORD_W'(i + 1)) hit[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_strb <= '0;
      cmd_code <= WORD_W'(CODE_NONE);
      cmd_err  <= 1'b0;
    end else begin
      cmd_err  <= sym_err;
      cmd_strb <= word_vld ? hit : '0;
      if (word_vld && (|hit)) cmd_code <= word;
    end
  end

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_strb)); // R9
  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|cmd_strb) |=> (cmd_strb == '0)); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (cmd_strb == '0)); // R9
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_strb == '0) |-> $stable(cmd_code)); // R6
endmodule

// File: rtl/mc_trig_cmd_rx.sv
module mc_trig_cmd_rx
  import mc_cmd_pkg::*;
#(
  parameter int HALF_CLKS   = 4,
  parameter int IDLE_HALVES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_line,
  output logic [NUM_CMD-1:0] cmd_strb,
  output logic [CMD_W-1:0]   cmd_code,
  output logic               cmd_err
);
  logic             line_s;
  logic             line_rise;
  logic             word_vld;
  logic [CMD_W-1:0] word;
  logic             sym_err;

  mc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_in(trig_line),
    .line_s(line_s), .line_rise(line_rise)
  );

  mc_framer #(.HALF_CLKS(HALF_CLKS), .IDLE_HALVES(IDLE_HALVES), .WORD_W(CMD_W)) u_framer (
    .clk(clk), .rst(rst), .line(line_s), .line_rise(line_rise),
    .word_vld(word_vld), .word(word), .sym_err(sym_err)
  );

  mc_decode #(.WORD_W(CMD_W), .N_CMD(NUM_CMD)) u_decode (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word), .sym_err(sym_err),
    .cmd_strb(cmd_strb), .cmd_code(cmd_code), .cmd_err(cmd_err)
  );
endmodule

// File: tb/tb_mc_trig_cmd_rx.sv
module tb_mc_trig_cmd_rx;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_line = 1'b0;
  logic [5:0] cmd_strb;
  logic [3:0] cmd_code;
  logic       cmd_err;

  int tests = 0, fails = 0;
  int strb_cnt = 0, err_cnt = 0;
  int strb_kind [6];
  bit done = 0;

  mc_trig_cmd_rx dut (.clk(clk), .rst(rst), .trig_line(trig_line),
    .cmd_strb(cmd_strb), .cmd_code(cmd_code), .cmd_err(cmd_err));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (|cmd_strb) strb_cnt++;
      if (cmd_err) err_cnt++;
      for (int i = 0; i < 6; i++) if (cmd_strb[i]) strb_kind[i]++;
    end
  end

  function automatic int exp_idx(input logic [3:0] c);
    return (c >= 4'h1 && c <= 4'h6) ? int'(c) - 1 : -1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic half(input logic v);
    trig_line = v;
    repeat (HALF) @(negedge clk);
  endtask

  // bad_bit: -1 none, 0 marker, 1..4 data bit; flattened bit keeps its first half level
  task automatic frame(input logic [3:0] c, input int idle, input int bad_bit);
    logic b;
    for (int i = 0; i < idle; i++) half(1'b0);
    for (int k = 0; k < 5; k++) begin
      b = (k == 0) ? 1'b1 : c[4-k];
      half(b);
      half((k == bad_bit) ? b : ~b);
    end
    trig_line = 1'b0;
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s0, e0, k0, c0;
    logic [3:0] code;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 strb after reset", cmd_strb, 0);
    check("R1 code after reset", cmd_code, 0);
    check("R1 err after reset", cmd_err, 0);

    // R4 R5 R2: every valid code, exact strobe cycle and single width
    for (int c = 1; c <= 6; c++) begin
      s0 = strb_cnt;
      frame(4'(c), 10, -1);
      @(negedge clk);
      check("R5 not early", cmd_strb, 0);
      @(negedge clk);
      check("R4 strobe bit", cmd_strb, 1 << (c - 1));
      check("R4 code", cmd_code, c);
      @(negedge clk);
      check("R5 single cycle", cmd_strb, 0);
      check("R5 one strobe", strb_cnt - s0, 1);
    end

    // R6: unused codes
    c0 = cmd_code;
    for (int c = 0; c < 16; c++) begin
      if (exp_idx(4'(c)) >= 0) continue;
      s0 = strb_cnt; e0 = err_cnt;
      frame(4'(c), 9, -1);
      quiet(6);
      check("R6 no strobe", strb_cnt - s0, 0);
      check("R6 no error", err_cnt - e0, 0);
      check("R6 code kept", cmd_code, c0);
    end

    // R7: flattened marker and flattened data bits
    for (int bb = 0; bb < 5; bb++) begin
      s0 = strb_cnt; e0 = err_cnt;
      frame(4'h3, 10, bb);
      quiet(6);
      check("R7 error pulse", err_cnt - e0, 1);
      check("R7 word dropped", strb_cnt - s0, 0);
    end

    // R3: idle too short before a good word
    s0 = strb_cnt;
    frame(4'h1, 10, 0);
    quiet(4);
    e0 = err_cnt;
    frame(4'h2, 4, -1);
    quiet(6);
    check("R3 short idle ignored", strb_cnt - s0, 0);
    check("R3 short idle no error", err_cnt - e0, 0);

    // R8: steady high for a long time, then steady low
    s0 = strb_cnt; e0 = err_cnt;
    for (int i = 0; i < 10; i++) half(1'b0);
    for (int i = 0; i < 30; i++) half(1'b1);
    for (int i = 0; i < 30; i++) half(1'b0);
    check("R8 no command from level", strb_cnt - s0, 0);
    check("R8 single error", err_cnt - e0, 1);

    // random frames
    for (int n = 0; n < 60; n++) begin
      int bad;
      code = 4'($urandom_range(0, 15));
      bad = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 4)) : -1;
      s0 = strb_cnt; e0 = err_cnt;
      k0 = (exp_idx(code) >= 0) ? strb_kind[exp_idx(code)] : 0;
      frame(code, 8 + int'($urandom_range(0, 6)), bad);
      quiet(6);
      if (bad >= 0) begin
        check("R7 random error", err_cnt - e0, 1);
        check("R7 random drop", strb_cnt - s0, 0);
      end else begin
        check("R6 random strobe count", strb_cnt - s0, exp_idx(code) >= 0 ? 1 : 0);
        if (exp_idx(code) >= 0) begin
          check("R4 random kind", strb_kind[exp_idx(code)] - k0, 1);
          check("R4 random code", cmd_code, code);
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule